// File: doc/BRIEF.md
# Prescaled Reference-Compare Timer

A 16-bit timer block behind a small synchronous register port. A programmable prescaler divides the system clock into count ticks. Each tick advances a 16-bit counter. When the counter arrives at a software-programmed reference value, the block latches a reference event flag and can assert an interrupt line. Software acknowledges the event by writing a one to the flag's bit.

One control word sets up the timer. It holds the run enable, a two-bit clock-source selector, the restart-on-match choice, the interrupt enable and an 8-bit prescale field. Dropping the enable bit from 1 to 0 acts as a soft reset that clears the control word and the reference value. A capture register is provided as plain storage. Its event bit is present in the event register but never sets, because input pin sampling is not part of this block.

Top module: `pscmp_timer`

## Requirements
- R1: After reset, every register offset reads zero and `irq` is low.
- R2: Byte offset 0x00 reads back the control word, 0x04 the reference and 0x08 the capture register; a write to 0x0C loads the counter, and a read there returns the current count; any other offset reads zero.
- R3: Control bit 0 enables counting and bits 2:1 select the clock source. With source 1, a tick occurs every (bits 15:8 + 1) system clocks, counted from the control-word write, so the count after n clocks is floor(n / divisor).
- R4: With clock source 2, the divisor of R3 is multiplied by 16.
- R5: Clock sources 0 and 3, or a cleared bit 0, hold the counter frozen.
- R6: With control bit 3 set, the tick after the counter equals the reference returns it to 0.
- R7: With control bit 3 clear, the counter runs past the reference and wraps from 0xFFFF to 0, while the match still sets the reference event.
- R8: Bit 1 of the byte-wide event register at offset 0x11 sets on the tick that brings the counter to the reference value; bit 0 (capture event) always reads 0.
- R9: Writing 1 to an event bit clears it; writing 0 leaves it unchanged; a clear that lands on the same clock as a new match leaves the flag set.
- R10: `irq` is high exactly when control bit 4 and event bit 1 are both set.
- R11: Writing the control word with bit 0 clear, while bit 0 was set, zeroes the control word and the reference but leaves the counter. The same write with bit 0 already clear stores the value as written.
- R12: Any write to the control word or the reference restarts the prescaler phase, so the next tick comes a full divisor later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 5 | Byte offset of the register accessed |
| wr_data | input | 16 | Write data; the event register uses bits 7:0 |
| rd_data | output | 16 | Read data for `addr`, combinational |
| irq | output | 1 | Reference-event interrupt |

## Verification
On every cycle, the bound checker enforces the following: a frozen counter stays put, restart-on-match returns the count to 0, the flag clears on a write-one, the interrupt obeys its enable, and an enable drop wipes the control word and the reference. A new event flag must also trace back to a tick. Only the bench's timed scenarios can show that the divisor arithmetic comes out right for both clock sources, that writes restart the prescaler phase, that the counter wraps when restart is off, and that a set beats a simultaneous clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CNT_W   = 16;
    localparam int ADDR_W  = 5;
    localparam int PSC_W   = 8;
    localparam int SLOW_DV = 16;
    localparam int EVT_W   = 2;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_REFV = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_CAPT = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_EVT  = 5'h11;

    typedef enum logic [1:0] {
        CS_STOP  = 2'd0,
        CS_SYS   = 2'd1,
        CS_SYS16 = 2'd2,
        CS_EXT   = 2'd3
    } clk_src_e;

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic [1:0]       cap_edge;
        logic             out_mode;
        logic             irq_en;
        logic             restart;
        logic [1:0]       src;
        logic             en;
    } ctrl_t;

    function automatic logic src_runs(input ctrl_t c);
        return c.en && (c.src == CS_SYS || c.src == CS_SYS16);
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PSC_W   = tmr_pkg::PSC_W,
    parameter int SLOW_DV = tmr_pkg::SLOW_DV
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clr,
    input  logic             slow,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    localparam int DIV_W = PSC_W + $clog2(SLOW_DV) + 1;

    logic [DIV_W-1:0] phase_q;
    logic [DIV_W-1:0] div_base;
    logic [DIV_W-1:0] div_full;

    always_comb begin
        div_base = DIV_W'(psc) + DIV_W'(1);
        div_full = slow ? div_base * DIV_W'(SLOW_DV) : div_base;
    end

    assign tick = run && !clr && (phase_q == div_full - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr || !run) begin
            phase_q <= '0;
        end else if (tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = tmr_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] refv,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic [CNT_W-1:0] count,
    output logic             match
);
    logic [CNT_W-1:0] nxt;

    always_comb begin
        if (restart && count == refv) nxt = '0;
        else                          nxt = count + CNT_W'(1);
    end

    assign match = tick && !ld && (nxt == refv);

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (ld)   count <= ld_val;
        else if (tick) count <= nxt;
    end
endmodule

// File: rtl/tmr_regfile.sv
module tmr_regfile
    import tmr_pkg::*;
#(
    parameter int CNT_W  = tmr_pkg::CNT_W,
    parameter int ADDR_W = tmr_pkg::ADDR_W,
    parameter int EVT_W  = tmr_pkg::EVT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [CNT_W-1:0]  count,
    input  logic              match,
    output ctrl_t             ctrl_q,
    output logic [CNT_W-1:0]  refv_q,
    output logic [EVT_W-1:0]  evt_q,
    output logic              cnt_ld,
    output logic              phase_clr,
    output logic [CNT_W-1:0]  rd_data
);
    logic [CNT_W-1:0] capt_q;
    logic             wr_ctrl, wr_refv, wr_capt, wr_evt;
    logic             wipe;
    logic [EVT_W-1:0] evt_set;

    assign wr_ctrl   = wr_en && addr == OFS_CTRL;
    assign wr_refv   = wr_en && addr == OFS_REFV;
    assign wr_capt   = wr_en && addr == OFS_CAPT;
    assign wr_evt    = wr_en && addr == OFS_EVT;
    assign cnt_ld    = wr_en && addr == OFS_CNT;
    assign phase_clr = wr_ctrl || wr_refv;
    assign wipe      = wr_ctrl && ctrl_q.en && !wr_data[0];
    assign evt_set   = {match, 1'b0};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            refv_q <= '0;
            capt_q <= '0;
        end else if (wipe) begin
            ctrl_q <= '0;
            refv_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_t'(wr_data);
        end else if (wr_refv) begin
            refv_q <= wr_data;
        end else if (wr_capt) begin
            capt_q <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) evt_q <= '0;
        else     evt_q <= (evt_q & ~(wr_evt ? wr_data[EVT_W-1:0] : '0)) | evt_set;
    end

    always_comb begin
        case (addr)
            OFS_CTRL: rd_data = CNT_W'(ctrl_q);
            OFS_REFV: rd_data = refv_q;
            OFS_CAPT: rd_data = capt_q;
            OFS_CNT:  rd_data = count;
            OFS_EVT:  rd_data = CNT_W'(evt_q);
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pscmp_timer.sv
module pscmp_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] refv_q;
    logic [CNT_W-1:0] count_q;
    logic [EVT_W-1:0] evt_q;
    logic             cnt_ld, phase_clr, tick, match, run;

    assign run = src_runs(ctrl_q);

    tmr_regfile u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .count(count_q), .match(match), .ctrl_q(ctrl_q), .refv_q(refv_q),
        .evt_q(evt_q), .cnt_ld(cnt_ld), .phase_clr(phase_clr), .rd_data(rd_data)
    );

    tmr_prescaler u_psc (
        .clk(clk), .rst(rst), .run(run), .clr(phase_clr),
        .slow(ctrl_q.src == CS_SYS16), .psc(ctrl_q.psc), .tick(tick)
    );

    tmr_counter u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .restart(ctrl_q.restart),
        .refv(refv_q), .ld(cnt_ld), .ld_val(wr_data),
        .count(count_q), .match(match)
    );

    assign irq = ctrl_q.irq_en && evt_q[1];
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [CNT_W-1:0]  wr_data,
    input logic              irq,
    input ctrl_t             ctrl_q,
    input logic [CNT_W-1:0]  refv_q,
    input logic [CNT_W-1:0]  count_q,
    input logic [EVT_W-1:0]  evt_q,
    input logic              tick,
    input logic              run
);
    AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!run && !(wr_en && addr == OFS_CNT)) |=> $stable(count_q)); // R5

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        tick |-> run); // R5

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
        (tick && ctrl_q.restart && count_q == refv_q && !(wr_en && addr == OFS_CNT))
        |=> count_q == '0); // R6

    AST_EVT_FROM_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(evt_q[1]) |-> $past(tick)); // R8

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_EVT && wr_data[1] && !tick) |=> !evt_q[1]); // R9

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.irq_en |-> !irq); // R10

    AST_ENABLE_DROP_WIPES: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFS_CTRL && ctrl_q.en && !wr_data[0])
        |=> (ctrl_q == '0 && refv_q == '0)); // R11
endmodule

bind pscmp_timer tmr_checker u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .irq(irq), .ctrl_q(ctrl_q), .refv_q(refv_q), .count_q(count_q),
    .evt_q(evt_q), .tick(tick), .run(run)
);

// File: tb/sim_pscmp_timer.sv
module sim_pscmp_timer;
    localparam logic [4:0] A_CTRL = 5'h00, A_REFV = 5'h04, A_CAPT = 5'h08,
                           A_CNT = 5'h0C, A_EVT = 5'h11;

    // {psc[7:0], src[1:0], cycles[15:0], expected count[15:0]}
    localparam int NVEC = 7;
    localparam logic [41:0] VEC [NVEC] = '{
        {8'd0, 2'd1, 16'd10,  16'd10},
        {8'd3, 2'd1, 16'd20,  16'd5},
        {8'd2, 2'd1, 16'd14,  16'd4},
        {8'd0, 2'd2, 16'd64,  16'd4},
        {8'd1, 2'd2, 16'd100, 16'd3},
        {8'd0, 2'd0, 16'd30,  16'd0},
        {8'd0, 2'd3, 16'd30,  16'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        irq;
    int          total = 0;
    int          bad = 0;
    bit          done = 0;

    pscmp_timer u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
                    .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    // call only after a negedge: reads combinationally
    task automatic rdchk(input string req, input logic [4:0] a, input logic [15:0] exp);
        addr = a;
        #1 chk(req, rd_data, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] cval;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        @(negedge clk);
        rdchk("R1 ctrl", A_CTRL, 16'h0);
        rdchk("R1 refv", A_REFV, 16'h0);
        rdchk("R1 capt", A_CAPT, 16'h0);
        rdchk("R1 cnt",  A_CNT,  16'h0);
        rdchk("R1 evt",  A_EVT,  16'h0);
        chk("R1 irq", {15'b0, irq}, 16'h0);

        // R2 register storage
        wr(A_CAPT, 16'hBEEF);
        wr(A_CNT, 16'h1234);
        wr(A_REFV, 16'h00A5);
        @(negedge clk);
        rdchk("R2 capt", A_CAPT, 16'hBEEF);
        rdchk("R2 cnt",  A_CNT,  16'h1234);
        rdchk("R2 refv", A_REFV, 16'h00A5);
        rdchk("R2 unused", 5'h10, 16'h0);

        // R3/R4/R5 divisor table
        for (int i = 0; i < NVEC; i++) begin
            logic [7:0] p;
            logic [1:0] s;
            logic [15:0] n, e;
            string tag;
            {p, s, n, e} = VEC[i];
            tag = (s == 2'd2) ? "R4 div16" : (s == 2'd1) ? "R3 divisor" : "R5 frozen";
            wr(A_CTRL, 16'h0);
            wr(A_CNT, 16'h0);
            wr(A_REFV, 16'hFFFF);
            wr(A_CTRL, {p, 5'b0, s, 1'b1});
            repeat (n) @(posedge clk);
            @(negedge clk);
            rdchk(tag, A_CNT, e);
        end

        // R5 enable off with running source
        wr(A_CTRL, 16'h0);
        wr(A_CNT, 16'h0007);
        wr(A_CTRL, 16'h0002);
        repeat (10) @(posedge clk);
        @(negedge clk);
        rdchk("R5 disabled", A_CNT, 16'h0007);

        // R12 phase restart on reference write
        wr(A_CTRL, 16'h0);
        wr(A_CNT, 16'h0);
        wr(A_REFV, 16'hFFFF);
        wr(A_CTRL, 16'h0303);
        repeat (2) @(posedge clk);
        wr(A_REFV, 16'hFFFF);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rdchk("R12 no tick yet", A_CNT, 16'h0);
        @(negedge clk);
        rdchk("R12 tick after full period", A_CNT, 16'h1);

        // R6/R8/R10 restart with interrupt
        wr(A_CTRL, 16'h0);
        wr(A_CNT, 16'h0);
        wr(A_EVT, 16'h0003);
        wr(A_REFV, 16'h0003);
        wr(A_CTRL, 16'h001B);
        repeat (5) @(posedge clk);
        @(negedge clk);
        rdchk("R6 restart", A_CNT, 16'h0001);
        rdchk("R8 ref event", A_EVT, 16'h0002);
        chk("R10 irq on", {15'b0, irq}, 16'h1);

        // freeze, keep enable
        wr(A_CTRL, 16'h0019);
        wr(A_CTRL, 16'h0009);
        @(negedge clk);
        chk("R10 irq masked", {15'b0, irq}, 16'h0);
        rdchk("R10 flag kept", A_EVT, 16'h0002);
        wr(A_EVT, 16'h0000);
        @(negedge clk);
        rdchk("R9 zero write", A_EVT, 16'h0002);
        wr(A_EVT, 16'h0002);
        @(negedge clk);
        rdchk("R9 w1c", A_EVT, 16'h0000);
        wr(A_CTRL, 16'h0019);
        @(negedge clk);
        chk("R10 irq no flag", {15'b0, irq}, 16'h0);

        // R11 soft reset on enable drop
        addr = A_CNT; #1 cval = rd_data;
        wr(A_CTRL, 16'h0310);
        @(negedge clk);
        rdchk("R11 ctrl wiped", A_CTRL, 16'h0);
        rdchk("R11 refv wiped", A_REFV, 16'h0);
        rdchk("R11 cnt kept", A_CNT, cval);
        wr(A_CTRL, 16'h0310);
        @(negedge clk);
        rdchk("R11 plain store", A_CTRL, 16'h0310);

        // R7 wrap without restart
        wr(A_CTRL, 16'h0);
        wr(A_CNT, 16'hFFFE);
        wr(A_REFV, 16'h0001);
        wr(A_EVT, 16'h0003);
        wr(A_CTRL, 16'h0003);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rdchk("R7 wrap count", A_CNT, 16'h0002);
        rdchk("R7 wrap flag", A_EVT, 16'h0002);

        // R9 set beats clear on the same clock
        wr(A_CTRL, 16'h0);
        wr(A_CNT, 16'h0);
        wr(A_EVT, 16'h0003);
        wr(A_REFV, 16'h0002);
        wr(A_CTRL, 16'h0003);
        @(posedge clk);
        wr(A_EVT, 16'h0002);
        wr(A_CTRL, 16'h0001);
        @(negedge clk);
        rdchk("R9 set wins", A_EVT, 16'h0002);
        rdchk("R8 capture bit", A_EVT, 16'h0002);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule